// File: doc/BRIEF.md
# Branch and Call Resolution Unit

This block resolves the control-flow instructions of a processor with 16-bit instruction words and 32-bit addresses. For each accepted instruction it takes the current PC, the instruction word, the four condition flags, a register operand (the value of the register the instruction names) and the current return-pointer value. One cycle later it reports the next PC, whether control flow was redirected, a request to write the return pointer together with the value to write, and how many cycles the instruction costs.

It covers conditional PC-relative branches, including the always and never forms, and PC-relative calls with an 11-bit displacement. It also covers register-indirect jumps and calls, and return through the return pointer. Any other instruction word falls through to PC+2. The block never changes the flags: it has no flag output. Fetch, the register file and hazard handling stay with the surrounding pipeline.

The request side is a valid/ready stream. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` drops for the extra cycles of a two-cycle instruction, and a request offered while it is low is not taken and has no effect. The result side has no back-pressure. `res_valid` is a single-cycle pulse in the cycle after a transfer, and the consumer must take the result in that cycle.

Top module: `bru_unit`

## Requirements
- R1: For a conditional branch (instruction bits [15:12] = 4'hE), the code in bits [11:8] decides the branch from the flags `req_flags` = {N,Z,V,C}. Codes 0 to 15 give, in order: always; never; Z; !Z; C; !C; N; !N; V; !V; V^N; !(V^N); (V^N)|Z; !((V^N)|Z); C|Z; !(C|Z).
- R2: A taken conditional branch goes to PC + 2 + 2*rel8, where rel8 is the signed value of instruction bits [7:0]. An untaken branch, including the never form, goes to PC+2 and reports not taken.
- R3: A conditional branch costs 2 cycles when taken and 1 cycle when not taken. Every call, jump and return costs 2 cycles.
- R4: A PC-relative call (bits [15:11] = 5'b11010) writes PC+2 to the return pointer and goes to PC + 2 + 2*rel11, where rel11 is the signed value of bits [10:0].
- R5: A register-indirect call (bits [15:4] = 12'h971) writes PC+2 to the return pointer and goes to `req_reg`.
- R6: A register-indirect jump (bits [15:4] = 12'h970) goes to `req_reg` and does not request a return-pointer write.
- R7: A return (word 16'h9720) goes to `req_rp` and does not request a return-pointer write.
- R8: All target arithmetic wraps modulo 2^32.
- R9: Any other instruction word goes to PC+2, is not taken, writes nothing and costs 1 cycle.
- R10: `res_valid` pulses for exactly the one cycle after each transfer. After a 2-cycle instruction `req_ready` stays low for one cycle, and a request offered during that cycle is ignored.
- R11: After reset `res_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request |
| req_pc | input | 32 | Address of the instruction |
| req_instr | input | 16 | Instruction word |
| req_flags | input | 4 | Flags {N,Z,V,C} |
| req_reg | input | 32 | Value of the named register operand |
| req_rp | input | 32 | Current return-pointer value |
| res_valid | output | 1 | Result pulse, one cycle after transfer |
| res_next_pc | output | 32 | Resolved next PC |
| res_taken | output | 1 | Control flow redirected |
| res_rp_we | output | 1 | Return-pointer write request |
| res_rp_wdata | output | 32 | Value for the return pointer |
| res_cycles | output | 2 | Cycle cost of the instruction |

## Verification
The condition map is tried with every one of the sixteen codes against all sixteen flag combinations. This separates each predicate from its inverse and from neighbouring codes, and catches any swap of flag bits. Branch and call displacements are tried at positive, negative, zero and extreme values, with PCs near both ends of the address space, so that errors in sign extension, scaling and wrap-around each give a distinct wrong target. Indirect jump, indirect call and return are given different register and return-pointer values, so that taking the wrong source or writing the return pointer when it should not be written shows up. A request held during the busy cycle checks that back-pressure drops it.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_BCC   = 3'd1,
    K_CALLR = 3'd2,
    K_CALLI = 3'd3,
    K_JMPI  = 3'd4,
    K_RET   = 3'd5
  } kind_e;

  localparam logic [3:0]  OP_BCC_HI   = 4'hE;
  localparam logic [4:0]  OP_CALLR_HI = 5'b11010;
  localparam logic [11:0] OP_JMPI_HI  = 12'h970;
  localparam logic [11:0] OP_CALLI_HI = 12'h971;
  localparam logic [15:0] OP_RET      = 16'h9720;

  // flag vector layout {N,Z,V,C}
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FV = 1;
  localparam int FC = 0;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  logic [IW-1:0] instr,
  output kind_e         kind,
  output logic [3:0]    code,
  output logic [AW-1:0] disp
);
  localparam int R8W  = 8;
  localparam int R11W = 11;

  logic [R8W-1:0]  rel8;
  logic [R11W-1:0] rel11;

  assign rel8  = instr[R8W-1:0];
  assign rel11 = instr[R11W-1:0];
  assign code  = instr[11:8];

  always_comb begin
    kind = K_NONE;
    if (instr[15:12] == OP_BCC_HI)        kind = K_BCC;
    else if (instr[15:11] == OP_CALLR_HI) kind = K_CALLR;
    else if (instr[15:4] == OP_JMPI_HI)   kind = K_JMPI;
    else if (instr[15:4] == OP_CALLI_HI)  kind = K_CALLI;
    else if (instr == OP_RET)             kind = K_RET;
  end

  // displacement in halfwords, sign-extended and scaled to bytes
  always_comb begin
    if (kind == K_CALLR)
      disp = {{(AW-R11W-1){rel11[R11W-1]}}, rel11, 1'b0};
    else
      disp = {{(AW-R8W-1){rel8[R8W-1]}}, rel8, 1'b0};
  end

  // R2
  disp_even_chk: assert final (disp[0] == 1'b0);
endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
(
  input  logic [3:0] flags,
  input  logic [3:0] code,
  output logic       take
);
  logic n, z, v, c, vn, base;

  assign n  = flags[FN];
  assign z  = flags[FZ];
  assign v  = flags[FV];
  assign c  = flags[FC];
  assign vn = v ^ n;

  // even codes test a predicate, the following odd code its inverse
  always_comb begin
    unique case (code[3:1])
      3'd0: base = 1'b1;
      3'd1: base = z;
      3'd2: base = c;
      3'd3: base = n;
      3'd4: base = v;
      3'd5: base = vn;
      3'd6: base = vn | z;
      default: base = c | z;
    endcase
    take = base ^ code[0];
  end

  // R1
  never_taken_chk: assert final (!(code == 4'd1 && take));
  // R1
  always_taken_chk: assert final (!(code == 4'd0 && !take));
endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] disp,
  output logic [AW-1:0] seq_pc,
  output logic [AW-1:0] rel_pc
);
  localparam logic [AW-1:0] STEP = AW'(2);

  // modulo 2^AW by truncation
  assign seq_pc = pc + STEP;
  assign rel_pc = seq_pc + disp;

  // R8
  rel_parity_chk: assert final (rel_pc[0] == pc[0]);
endmodule

// File: rtl/bru_unit.sv
module bru_unit
  import bru_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_pc,
  input  logic [IW-1:0] req_instr,
  input  logic [3:0]    req_flags,
  input  logic [AW-1:0] req_reg,
  input  logic [AW-1:0] req_rp,
  output logic          res_valid,
  output logic [AW-1:0] res_next_pc,
  output logic          res_taken,
  output logic          res_rp_we,
  output logic [AW-1:0] res_rp_wdata,
  output logic [CW-1:0] res_cycles
);
  localparam logic [CW-1:0] CYC_SHORT = CW'(1);
  localparam logic [CW-1:0] CYC_LONG  = CW'(2);

  kind_e         kind;
  logic [3:0]    code;
  logic [AW-1:0] disp, seq_pc, rel_pc;
  logic          take;

  logic [AW-1:0] nx_pc;
  logic          nx_taken, nx_we;
  logic [CW-1:0] nx_cyc;
  logic [CW-1:0] busy_cnt;
  logic          acc;

  bru_decode #(.AW(AW), .IW(IW)) u_dec (
    .instr(req_instr), .kind(kind), .code(code), .disp(disp)
  );

  bru_cond u_cond (.flags(req_flags), .code(code), .take(take));

  bru_target #(.AW(AW)) u_tgt (
    .pc(req_pc), .disp(disp), .seq_pc(seq_pc), .rel_pc(rel_pc)
  );

  always_comb begin
    nx_pc    = seq_pc;
    nx_taken = 1'b1;
    nx_we    = 1'b0;
    nx_cyc   = CYC_LONG;
    unique case (kind)
      K_BCC: begin
        nx_taken = take;
        nx_pc    = take ? rel_pc : seq_pc;
        nx_cyc   = take ? CYC_LONG : CYC_SHORT;
      end
      K_CALLR: begin
        nx_pc = rel_pc;
        nx_we = 1'b1;
      end
      K_CALLI: begin
        nx_pc = req_reg;
        nx_we = 1'b1;
      end
      K_JMPI:  nx_pc = req_reg;
      K_RET:   nx_pc = req_rp;
      default: begin
        nx_taken = 1'b0;
        nx_cyc   = CYC_SHORT;
      end
    endcase
  end

  assign req_ready = (busy_cnt == '0);
  assign acc       = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (acc) begin
      busy_cnt <= nx_cyc - CW'(1);
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_next_pc  <= '0;
      res_taken    <= 1'b0;
      res_rp_we    <= 1'b0;
      res_rp_wdata <= '0;
      res_cycles   <= '0;
    end else begin
      res_valid <= acc;
      if (acc) begin
        res_next_pc  <= nx_pc;
        res_taken    <= nx_taken;
        res_rp_we    <= nx_we;
        res_rp_wdata <= seq_pc;
        res_cycles   <= nx_cyc;
      end
    end
  end

  // R10
  result_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid);
  // R10
  no_result_without_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !res_valid);
  // R10
  busy_after_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && nx_cyc == CYC_LONG) |=> !req_ready);
  // R3
  taken_costs_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken) |-> (res_cycles == CYC_LONG));
  // R9
  write_implies_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_rp_we) |-> res_taken);
endmodule

// File: tb/bru_unit_tb.sv
`timescale 1ns/1ps
module bru_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_pc = '0;
  logic [15:0] req_instr = '0;
  logic [3:0]  req_flags = '0;
  logic [31:0] req_reg = '0;
  logic [31:0] req_rp = '0;
  logic        res_valid;
  logic [31:0] res_next_pc;
  logic        res_taken;
  logic        res_rp_we;
  logic [31:0] res_rp_wdata;
  logic [1:0]  res_cycles;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  bru_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pc(req_pc), .req_instr(req_instr), .req_flags(req_flags),
    .req_reg(req_reg), .req_rp(req_rp), .res_valid(res_valid),
    .res_next_pc(res_next_pc), .res_taken(res_taken), .res_rp_we(res_rp_we),
    .res_rp_wdata(res_rp_wdata), .res_cycles(res_cycles)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model of the condition map, flags {N,Z,V,C}
  function automatic bit model_take(input logic [3:0] cd, input logic [3:0] f);
    bit n, z, v, c;
    {n, z, v, c} = f;
    case (cd)
      4'd0:  return 1'b1;
      4'd1:  return 1'b0;
      4'd2:  return z;
      4'd3:  return !z;
      4'd4:  return c;
      4'd5:  return !c;
      4'd6:  return n;
      4'd7:  return !n;
      4'd8:  return v;
      4'd9:  return !v;
      4'd10: return v ^ n;
      4'd11: return !(v ^ n);
      4'd12: return (v ^ n) | z;
      4'd13: return !((v ^ n) | z);
      4'd14: return c | z;
      default: return !(c | z);
    endcase
  endfunction

  function automatic logic [31:0] sx8(input logic [7:0] r);
    return {{23{r[7]}}, r, 1'b0};
  endfunction

  function automatic logic [31:0] sx11(input logic [10:0] r);
    return {{20{r[10]}}, r, 1'b0};
  endfunction

  // present one request; returns at the negedge after the transfer edge
  task automatic issue(input logic [31:0] pc, input logic [15:0] ins,
                       input logic [3:0] f, input logic [31:0] rv, input logic [31:0] rp);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_pc = pc; req_instr = ins; req_flags = f; req_reg = rv; req_rp = rp;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic [31:0] npc, input bit tk,
                            input bit we, input logic [31:0] wd, input logic [1:0] cyc);
    chk({tag, " valid"}, {31'd0, res_valid}, 32'd1);
    chk({tag, " next_pc"}, res_next_pc, npc);
    chk({tag, " taken"}, {31'd0, res_taken}, {31'd0, tk});
    chk({tag, " rp_we"}, {31'd0, res_rp_we}, {31'd0, we});
    if (we) chk({tag, " rp_wdata"}, res_rp_wdata, wd);
    chk({tag, " R3 cycles"}, {30'd0, res_cycles}, {30'd0, cyc});
    chk({tag, " R10 ready"}, {31'd0, req_ready}, {31'd0, cyc == 2'd1});
  endtask

  task automatic t_reset;
    chk("R11 res_valid", {31'd0, res_valid}, 32'd0);
    chk("R11 req_ready", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_cond_table;
    logic [31:0] pc;
    logic [7:0]  r;
    bit          tk;
    pc = 32'h0000_4000;
    r  = 8'hF6;
    for (int cd = 0; cd < 16; cd++) begin
      for (int f = 0; f < 16; f++) begin
        tk = model_take(4'(cd), 4'(f));
        issue(pc, {4'hE, 4'(cd), r}, 4'(f), 32'h0, 32'h0);
        expect_res("R1 R2 cond", tk ? pc + 32'd2 + sx8(r) : pc + 32'd2, tk, 1'b0, 32'h0,
                   tk ? 2'd2 : 2'd1);
      end
    end
  endtask

  task automatic t_branch_targets;
    issue(32'h0000_1000, 16'hE07F, 4'h0, 32'h0, 32'h0);
    expect_res("R2 fwd max", 32'h0000_1000 + 32'd2 + 32'd254, 1'b1, 1'b0, 0, 2'd2);
    issue(32'h0000_0010, 16'hE080, 4'h0, 32'h0, 32'h0);
    expect_res("R2 R8 back min", 32'hFFFF_FF12, 1'b1, 1'b0, 0, 2'd2);
    issue(32'hFFFF_FFFE, 16'hE001, 4'h0, 32'h0, 32'h0);
    expect_res("R8 wrap fwd", 32'h0000_0002, 1'b1, 1'b0, 0, 2'd2);
    issue(32'h0000_2000, 16'hE100, 4'hF, 32'h0, 32'h0);
    expect_res("R2 never", 32'h0000_2002, 1'b0, 1'b0, 0, 2'd1);
    issue(32'h0000_3000, 16'hE000, 4'h0, 32'h0, 32'h0);
    expect_res("R2 zero disp", 32'h0000_3002, 1'b1, 1'b0, 0, 2'd2);
  endtask

  task automatic t_calls;
    issue(32'h0001_0000, 16'hD3FF, 4'h5, 32'h0, 32'h0);
    expect_res("R4 call fwd", 32'h0001_0002 + sx11(11'h3FF), 1'b1, 1'b1, 32'h0001_0002, 2'd2);
    issue(32'h0000_0100, 16'hD400, 4'h0, 32'h0, 32'h0);
    expect_res("R4 R8 call back", 32'h0000_0102 + sx11(11'h400), 1'b1, 1'b1, 32'h0000_0102, 2'd2);
    issue(32'h0002_0000, 16'h9713, 4'h0, 32'hCAFE_0010, 32'h1111_2222);
    expect_res("R5 call reg", 32'hCAFE_0010, 1'b1, 1'b1, 32'h0002_0002, 2'd2);
    issue(32'hFFFF_FFFE, 16'h9710, 4'h0, 32'h0000_0400, 32'h0);
    expect_res("R5 R8 call reg wrap", 32'h0000_0400, 1'b1, 1'b1, 32'h0000_0000, 2'd2);
  endtask

  task automatic t_jmp_ret;
    issue(32'h0003_0000, 16'h9705, 4'hA, 32'hBEEF_0020, 32'h1234_5678);
    expect_res("R6 jmp reg", 32'hBEEF_0020, 1'b1, 1'b0, 0, 2'd2);
    issue(32'h0004_0000, 16'h9720, 4'h3, 32'hBEEF_0020, 32'h1234_5678);
    expect_res("R7 ret", 32'h1234_5678, 1'b1, 1'b0, 0, 2'd2);
  endtask

  task automatic t_other;
    issue(32'h0005_0000, 16'h9721, 4'h0, 32'h7777_0000, 32'h8888_0000);
    expect_res("R9 near ret", 32'h0005_0002, 1'b0, 1'b0, 0, 2'd1);
    issue(32'h0005_0010, 16'h9730, 4'h0, 32'h7777_0000, 32'h8888_0000);
    expect_res("R9 near jmp", 32'h0005_0012, 1'b0, 1'b0, 0, 2'd1);
    issue(32'hFFFF_FFFE, 16'h1234, 4'h0, 32'h0, 32'h0);
    expect_res("R9 R8 plain wrap", 32'h0000_0000, 1'b0, 1'b0, 0, 2'd1);
  endtask

  task automatic t_busy_ignore;
    issue(32'h0006_0000, 16'hE004, 4'h0, 32'h0, 32'h0);
    expect_res("R10 busy lead", 32'h0006_000A, 1'b1, 1'b0, 0, 2'd2);
    req_pc = 32'h0007_0000; req_instr = 16'hD001; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R10 busy req ignored", {31'd0, res_valid}, 32'd0);
    chk("R10 ready back", {31'd0, req_ready}, 32'd1);
    chk("R10 old next_pc kept", res_next_pc, 32'h0006_000A);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 no late result", {31'd0, res_valid}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cond_table();
    t_branch_targets();
    t_calls();
    t_jmp_ret();
    t_other();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule